// File: doc/BRIEF.md
# UART Interrupt Priority Identification Unit

This block gathers every interrupt condition of a serial port and shows the most urgent one as a 6-bit identity code, together with a single interrupt request line. The receiver, transmitter, line-status, modem-status and flow-control logic drive condition pulses and levels into it. Enable masks and mode bits select which sources may interrupt.

Each source keeps its own pending state and clears by its own rule. The receiver error flags clear on a line-status read, and the modem delta flags clear on a modem-status read. The receive time-out clears on a receive-data read. Transmit-empty, special-character and pin-change conditions clear when the status read returns their own code.

The code presented to the bus is a register. It is frozen while the status read strobe is high, so a read-to-clear only removes the level that was returned.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the code is 000001, `irq` is low, and every pending latch is clear.
- R2: Codes: none 000001, receiver status 000110, receive data 000100, receive time-out 001100, transmit empty 000010, modem change 000000, special character 010000, pin change 100000. Bit 0 is 1 only when nothing is pending, and `irq` is the inverse of bit 0.
- R3: When several sources are pending, the code shows the highest one. The order from highest to lowest is receiver status, receive data, receive time-out, transmit empty, modem change, special character, pin change.
- R4: A pulse on any bit of `lsr_err_set` sets a sticky error flag. The flags clear on `lsr_rd`. The source is reported only while `en_rx_status` is 1.
- R5: With `en_rx_data` set, receive data is reported exactly while `rx_level` is greater than `rx_trig`.
- R6: A `rx_timeout` pulse latches the time-out source, which is reported under `en_rx_data`. A `rhr_rd` strobe clears it.
- R7: The transmit-empty latch sets on the cycle its condition becomes true (normally `tx_level < tx_trig`). It clears on a status read that returns 000010, or on `thr_wr` while `tx_level >= tx_trig`.
- R8: With `enh_trig_en` = 1 and `tx_trig` = 0, the transmit-empty condition is `tx_level` = 0, `tx_shift_empty` = 1 and `txd_idle` = 1, all at once.
- R9: A pulse on any bit of `msr_delta_set` sets a sticky modem flag. The flags clear on `msr_rd`. The source is reported only under `en_modem`.
- R10: Codes 010000 and 100000 are never shown while `enhanced` = 0. A latched source stays pending and appears once `enhanced` = 1. Each of these two clears on a status read that returns its own code.
- R11: While `isr_rd` is high, `isr_code` holds its value. A status read clears only the source whose code was returned, and `isr_code` follows the new state one cycle after the read ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_rx_status | input | 1 | Receiver status source enable |
| en_rx_data | input | 1 | Receive data and time-out enable |
| en_tx_empty | input | 1 | Transmit empty enable |
| en_modem | input | 1 | Modem change enable |
| en_special | input | 1 | Special character enable |
| en_pins | input | 1 | Pin change enable |
| enhanced | input | 1 | Enhanced mode, gates the two lowest levels |
| enh_trig_en | input | 1 | Enhanced trigger levels in use |
| lsr_err_set | input | 4 | Overrun, parity, framing and break event pulses |
| lsr_rd | input | 1 | Line-status read strobe |
| rx_level | input | LW | Receive FIFO fill level |
| rx_trig | input | LW | Receive trigger level |
| rx_timeout | input | 1 | Receive time-out event pulse |
| rhr_rd | input | 1 | Receive holding register read strobe |
| tx_level | input | LW | Transmit FIFO fill level |
| tx_trig | input | LW | Transmit trigger level |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| txd_idle | input | 1 | Serial output idle at mark |
| thr_wr | input | 1 | Transmit holding register write strobe |
| msr_delta_set | input | 4 | Modem delta event pulses |
| msr_rd | input | 1 | Modem-status read strobe |
| special_evt | input | 1 | Special character or XOFF match pulse |
| pin_chg_evt | input | 1 | CTS/RTS change pulse |
| isr_rd | input | 1 | Status read strobe |
| isr_code | output | 6 | Highest-priority identity code |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default depth of 16, which gives 5-bit levels. With this depth the trigger comparisons can sit at, just above and just below the trigger, and a trigger of zero selects the strict transmit-empty rule. These small levels let every priority pairing and every clearing rule run within a few hundred cycles. They also let a read be held open across a higher-priority event, which shows that the returned code is frozen.

// File: rtl/uart_irq_pkg.sv
// Package: shared identity codes and source indices for the interrupt unit.
// Assumes: index 0 is the highest priority; larger indices are lower.
package uart_irq_pkg;

    typedef enum logic [5:0] {
        ID_NONE    = 6'b000001,
        ID_RX_STAT = 6'b000110,
        ID_RX_DATA = 6'b000100,
        ID_RX_TMO  = 6'b001100,
        ID_TX_EMPT = 6'b000010,
        ID_MODEM   = 6'b000000,
        ID_SPECIAL = 6'b010000,
        ID_PINS    = 6'b100000
    } irq_id_e;

    localparam int N_SRC     = 7;
    localparam int S_RX_STAT = 0;
    localparam int S_RX_DATA = 1;
    localparam int S_RX_TMO  = 2;
    localparam int S_TX_EMPT = 3;
    localparam int S_MODEM   = 4;
    localparam int S_SPECIAL = 5;
    localparam int S_PINS    = 6;
    localparam int N_ENH     = 2;   // lowest N_ENH levels need enhanced mode

    // Map a source index to its identity code.
    function automatic irq_id_e id_of(input int idx);
        case (idx)
            S_RX_STAT: id_of = ID_RX_STAT;
            S_RX_DATA: id_of = ID_RX_DATA;
            S_RX_TMO:  id_of = ID_RX_TMO;
            S_TX_EMPT: id_of = ID_TX_EMPT;
            S_MODEM:   id_of = ID_MODEM;
            S_SPECIAL: id_of = ID_SPECIAL;
            default:   id_of = ID_PINS;
        endcase
    endfunction

endpackage

// File: rtl/irq_sticky.sv
// Module: a vector of sticky flags, each set by its own pulse, all cleared
// by one shared strobe. A set and a clear in the same cycle leave the flag set.
// Assumes: set pulses are one cycle wide and synchronous to clk.
module irq_sticky #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         clr,
    output logic [W-1:0] q
);

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            // Hold, clear or set one flag.
            always_ff @(posedge clk) begin
                if (!rst_n)       q[gi] <= 1'b0;
                else if (set[gi]) q[gi] <= 1'b1;
                else if (clr)     q[gi] <= 1'b0;
            end
        end
    endgenerate

    // R4 R9: a clear with no set leaves every flag low.
    p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set == '0) |=> (q == '0));

    // R4 R9: a set pulse is always visible on the next cycle.
    p_set_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((q & $past(set)) == $past(set)));

endmodule

// File: rtl/irq_tx_empty.sv
// Module: transmit-empty detector. It latches on the rising edge of the
// empty condition and clears on a matching status read or on a write that
// leaves the FIFO at or above its trigger.
// Assumes: tx_level already reflects any write of the same cycle.
module irq_tx_empty #(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] tx_trig,
    input  logic          enh_trig_en,
    input  logic          tx_shift_empty,
    input  logic          txd_idle,
    input  logic          thr_wr,
    input  logic          rd_hit,
    output logic          pend
);

    logic strict;
    logic cond;
    logic cond_q;
    logic set_p;
    logic clr_p;

    // Choose the empty condition: the strict zero-trigger rule or the level compare.
    always_comb begin
        strict = enh_trig_en && (tx_trig == '0);
        if (strict) cond = (tx_level == '0) && tx_shift_empty && txd_idle;
        else        cond = (tx_level < tx_trig);
        set_p  = cond && !cond_q;
        clr_p  = rd_hit || (thr_wr && (tx_level >= tx_trig));
    end

    // Remember the previous condition for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cond;
    end

    // Pending latch: a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend <= 1'b0;
        else if (set_p) pend <= 1'b1;
        else if (clr_p) pend <= 1'b0;
    end

    // R8: in strict mode the latch only rises with a fully idle transmitter.
    p_strict_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && strict && tx_trig == $past(tx_trig)) ##1 pend |->
        ($past(tx_level) == '0 && $past(tx_shift_empty) && $past(txd_idle)));

    // R7: a clear with no new edge drops the latch.
    p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_p && !set_p) |=> !pend);

endmodule

// File: rtl/irq_prio_resolve.sv
// Module: resolves the masked source vector into one identity code. The
// lowest N_ENH levels are suppressed unless enhanced mode is on.
// Assumes: src bits are already gated by their individual enables.
module irq_prio_resolve
    import uart_irq_pkg::*;
(
    input  logic [N_SRC-1:0] src,
    input  logic             enhanced,
    output irq_id_e          id
);

    logic [N_SRC-1:0] eff;

    genvar gi;
    generate
        for (gi = 0; gi < N_SRC; gi++) begin : g_gate
            if (gi >= N_SRC - N_ENH) begin : g_enh
                assign eff[gi] = src[gi] && enhanced;
            end else begin : g_std
                assign eff[gi] = src[gi];
            end
        end
    endgenerate

    // Scan from lowest to highest priority so the highest one wins.
    always_comb begin
        id = ID_NONE;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (eff[i]) id = id_of(i);
        end
    end

    // R3: the top-priority source always takes the code.
    always_comb begin
        a_top_wins_r3: assert (!src[S_RX_STAT] || id == ID_RX_STAT);
        // R10: enhanced-only codes never leave while enhanced mode is off.
        a_enh_gate_r10: assert (enhanced || (id != ID_SPECIAL && id != ID_PINS));
    end

endmodule

// File: rtl/uart_irq_ident.sv
// Module: top of the interrupt identification unit. It holds the pending
// state of each source, masks it, resolves priority and presents a code
// register that is frozen during a status read.
// Assumes: all strobes are synchronous single-cycle or level signals on clk.
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int N_LSR = 4,
    parameter int N_MSR = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_rx_status,
    input  logic          en_rx_data,
    input  logic          en_tx_empty,
    input  logic          en_modem,
    input  logic          en_special,
    input  logic          en_pins,
    input  logic          enhanced,
    input  logic          enh_trig_en,
    input  logic [N_LSR-1:0] lsr_err_set,
    input  logic          lsr_rd,
    input  logic [LW-1:0] rx_level,
    input  logic [LW-1:0] rx_trig,
    input  logic          rx_timeout,
    input  logic          rhr_rd,
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] tx_trig,
    input  logic          tx_shift_empty,
    input  logic          txd_idle,
    input  logic          thr_wr,
    input  logic [N_MSR-1:0] msr_delta_set,
    input  logic          msr_rd,
    input  logic          special_evt,
    input  logic          pin_chg_evt,
    input  logic          isr_rd,
    output logic [5:0]    isr_code,
    output logic          irq
);

    irq_id_e          code_q;
    irq_id_e          code_d;
    logic [N_LSR-1:0] lsr_q;
    logic [N_MSR-1:0] msr_q;
    logic             tmo_q;
    logic             spc_q;
    logic             pin_q;
    logic             tx_q;
    logic             hit_tx;
    logic             hit_spc;
    logic             hit_pin;
    logic [N_SRC-1:0] src;

    // Read hits use the frozen code, so only the returned level clears.
    always_comb begin
        hit_tx  = isr_rd && (code_q == ID_TX_EMPT);
        hit_spc = isr_rd && (code_q == ID_SPECIAL);
        hit_pin = isr_rd && (code_q == ID_PINS);
    end

    irq_sticky #(.W(N_LSR)) u_lsr (
        .clk(clk), .rst_n(rst_n), .set(lsr_err_set), .clr(lsr_rd), .q(lsr_q));

    irq_sticky #(.W(N_MSR)) u_msr (
        .clk(clk), .rst_n(rst_n), .set(msr_delta_set), .clr(msr_rd), .q(msr_q));

    irq_sticky #(.W(1)) u_tmo (
        .clk(clk), .rst_n(rst_n), .set(rx_timeout), .clr(rhr_rd), .q(tmo_q));

    irq_sticky #(.W(1)) u_spc (
        .clk(clk), .rst_n(rst_n), .set(special_evt), .clr(hit_spc), .q(spc_q));

    irq_sticky #(.W(1)) u_pin (
        .clk(clk), .rst_n(rst_n), .set(pin_chg_evt), .clr(hit_pin), .q(pin_q));

    irq_tx_empty #(.LW(LW)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .tx_trig(tx_trig),
        .enh_trig_en(enh_trig_en), .tx_shift_empty(tx_shift_empty),
        .txd_idle(txd_idle), .thr_wr(thr_wr), .rd_hit(hit_tx), .pend(tx_q));

    // Apply the per-source enables to form the request vector.
    always_comb begin
        src            = '0;
        src[S_RX_STAT] = en_rx_status && (|lsr_q);
        src[S_RX_DATA] = en_rx_data && (rx_level > rx_trig);
        src[S_RX_TMO]  = en_rx_data && tmo_q;
        src[S_TX_EMPT] = en_tx_empty && tx_q;
        src[S_MODEM]   = en_modem && (|msr_q);
        src[S_SPECIAL] = en_special && spc_q;
        src[S_PINS]    = en_pins && pin_q;
    end

    irq_prio_resolve u_prio (.src(src), .enhanced(enhanced), .id(code_d));

    // Code register: follows the resolver except while a status read is open.
    always_ff @(posedge clk) begin
        if (!rst_n)       code_q <= ID_NONE;
        else if (!isr_rd) code_q <= code_d;
    end

    assign isr_code = code_q;
    assign irq      = ~code_q[0];

    // R2: bit 0 set means the whole code is the idle code.
    p_bit0_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        isr_code[0] |-> (isr_code == 6'b000001));

    // R11: the code cannot move during a multi-cycle read.
    p_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && $past(isr_rd) && $past(rst_n)) |-> $stable(isr_code));

    // R11: a read that returned a lower code leaves the special latch alone.
    p_no_side_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (spc_q && isr_rd && code_q != ID_SPECIAL) |=> spc_q);

endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;

    localparam int DEPTH = 16;
    localparam int LW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_rx_status = 0, en_rx_data = 0, en_tx_empty = 0, en_modem = 0;
    logic en_special = 0, en_pins = 0, enhanced = 0, enh_trig_en = 0;
    logic [3:0] lsr_err_set = '0;
    logic lsr_rd = 0;
    logic [LW-1:0] rx_level = '0, rx_trig = 5'd4;
    logic rx_timeout = 0, rhr_rd = 0;
    logic [LW-1:0] tx_level = '0, tx_trig = 5'd8;
    logic tx_shift_empty = 1, txd_idle = 1, thr_wr = 0;
    logic [3:0] msr_delta_set = '0;
    logic msr_rd = 0, special_evt = 0, pin_chg_evt = 0, isr_rd = 0;
    logic [5:0] isr_code;
    logic irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    uart_irq_ident #(.DEPTH(DEPTH)) i_uart_irq_ident (
        .clk(clk), .rst_n(rst_n),
        .en_rx_status(en_rx_status), .en_rx_data(en_rx_data),
        .en_tx_empty(en_tx_empty), .en_modem(en_modem),
        .en_special(en_special), .en_pins(en_pins),
        .enhanced(enhanced), .enh_trig_en(enh_trig_en),
        .lsr_err_set(lsr_err_set), .lsr_rd(lsr_rd),
        .rx_level(rx_level), .rx_trig(rx_trig),
        .rx_timeout(rx_timeout), .rhr_rd(rhr_rd),
        .tx_level(tx_level), .tx_trig(tx_trig),
        .tx_shift_empty(tx_shift_empty), .txd_idle(txd_idle), .thr_wr(thr_wr),
        .msr_delta_set(msr_delta_set), .msr_rd(msr_rd),
        .special_evt(special_evt), .pin_chg_evt(pin_chg_evt),
        .isr_rd(isr_rd), .isr_code(isr_code), .irq(irq));

    task automatic chk(input string req, input logic [5:0] got, input logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Let latch and code register catch up, then sample mid-cycle.
    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    // Status read of one cycle; returns the code seen while the read is open.
    task automatic read_isr(output logic [5:0] v);
        isr_rd = 1;
        @(negedge clk);
        v = isr_code;
        isr_rd = 0;
        settle();
    endtask

    task automatic t_reset();
        chk("R1 code", isr_code, 6'b000001);
        chk("R1 irq", {5'b0, irq}, 6'd0);
    endtask

    task automatic t_rx_status();
        lsr_err_set = 4'b0100; @(negedge clk); lsr_err_set = '0;
        settle();
        chk("R4 masked", isr_code, 6'b000001);
        en_rx_status = 1; settle();
        chk("R4 enabled", isr_code, 6'b000110);
        chk("R2 irq high", {5'b0, irq}, 6'd1);
        lsr_rd = 1; @(negedge clk); lsr_rd = 0; settle();
        chk("R4 lsr read clears", isr_code, 6'b000001);
        chk("R2 irq low", {5'b0, irq}, 6'd0);
    endtask

    task automatic t_rx_data();
        en_rx_data = 1;
        rx_level = 5'd4; settle();
        chk("R5 at trigger", isr_code, 6'b000001);
        rx_level = 5'd5; settle();
        chk("R5 above trigger", isr_code, 6'b000100);
        rx_level = 5'd0; settle();
    endtask

    task automatic t_timeout();
        rx_timeout = 1; @(negedge clk); rx_timeout = 0; settle();
        chk("R6 time-out", isr_code, 6'b001100);
        rhr_rd = 1; @(negedge clk); rhr_rd = 0; settle();
        chk("R6 rhr read clears", isr_code, 6'b000001);
    endtask

    task automatic t_priority();
        rx_timeout = 1; lsr_err_set = 4'b0001; rx_level = 5'd9;
        @(negedge clk); rx_timeout = 0; lsr_err_set = '0; settle();
        chk("R3 status first", isr_code, 6'b000110);
        lsr_rd = 1; @(negedge clk); lsr_rd = 0; settle();
        chk("R3 data next", isr_code, 6'b000100);
        rx_level = 5'd1; settle();
        chk("R3 time-out next", isr_code, 6'b001100);
        rhr_rd = 1; @(negedge clk); rhr_rd = 0; settle();
    endtask

    task automatic t_tx();
        logic [5:0] v;
        en_tx_empty = 1; settle();
        chk("R7 empty since reset", isr_code, 6'b000010);
        read_isr(v);
        chk("R7 read returns code", v, 6'b000010);
        chk("R7 read clears", isr_code, 6'b000001);
        tx_level = 5'd10; thr_wr = 1; @(negedge clk); thr_wr = 0; settle();
        tx_level = 5'd5; settle();
        chk("R7 falls below trigger", isr_code, 6'b000010);
        tx_level = 5'd8; thr_wr = 1; @(negedge clk); thr_wr = 0; settle();
        chk("R7 write to trigger clears", isr_code, 6'b000001);
    endtask

    task automatic t_strict();
        enh_trig_en = 1; tx_trig = '0; tx_level = '0; tx_shift_empty = 0; txd_idle = 0;
        settle();
        chk("R8 shift busy", isr_code, 6'b000001);
        tx_shift_empty = 1; settle();
        chk("R8 line busy", isr_code, 6'b000001);
        txd_idle = 1; settle();
        chk("R8 fully idle", isr_code, 6'b000010);
        tx_trig = 5'd8; thr_wr = 1; tx_level = 5'd9; @(negedge clk); thr_wr = 0;
        enh_trig_en = 0; settle();
        chk("R7 cleared after strict", isr_code, 6'b000001);
    endtask

    task automatic t_modem();
        en_modem = 1;
        msr_delta_set = 4'b1000; @(negedge clk); msr_delta_set = '0; settle();
        chk("R9 modem change", isr_code, 6'b000000);
        msr_rd = 1; @(negedge clk); msr_rd = 0; settle();
        chk("R9 msr read clears", isr_code, 6'b000001);
    endtask

    task automatic t_enhanced();
        logic [5:0] v;
        en_special = 1; en_pins = 1;
        special_evt = 1; @(negedge clk); special_evt = 0; settle();
        chk("R10 gated off", isr_code, 6'b000001);
        enhanced = 1; settle();
        chk("R10 shown when enhanced", isr_code, 6'b010000);
        msr_delta_set = 4'b0001; @(negedge clk); msr_delta_set = '0; settle();
        read_isr(v);
        chk("R11 read returns modem", v, 6'b000000);
        chk("R11 special kept", isr_code, 6'b000000);
        msr_rd = 1; @(negedge clk); msr_rd = 0; settle();
        chk("R10 special after modem", isr_code, 6'b010000);
        read_isr(v);
        chk("R10 special read clears", isr_code, 6'b000001);
        pin_chg_evt = 1; @(negedge clk); pin_chg_evt = 0; settle();
        chk("R10 pin change", isr_code, 6'b100000);
        read_isr(v);
        chk("R10 pin read clears", isr_code, 6'b000001);
    endtask

    task automatic t_read_hold();
        tx_level = 5'd3; settle();
        chk("R11 tx pending", isr_code, 6'b000010);
        isr_rd = 1; lsr_err_set = 4'b0010; @(negedge clk); lsr_err_set = '0;
        @(negedge clk);
        chk("R11 held during read", isr_code, 6'b000010);
        isr_rd = 0; settle();
        chk("R11 new level after read", isr_code, 6'b000110);
        lsr_rd = 1; @(negedge clk); lsr_rd = 0; settle();
        chk("R11 tx was cleared by read", isr_code, 6'b000001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_rx_status();
        t_rx_data();
        t_timeout();
        t_priority();
        t_tx();
        t_strict();
        t_modem();
        t_enhanced();
        t_read_hold();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule